// File: doc/BRIEF.md
# Receive Buffer Packet Skip Controller

This block owns the host side of a circular receive packet buffer. A producer streams packet bytes in, and a packet becomes visible to the host only once its final byte has been accepted. Each packet begins with a 4-byte header whose bytes 2 and 3 hold the payload length in little-endian order (byte 2 is the low byte). The host pulls bytes out through a valid/ready output stream. The read pointer advances by one on every accepted byte, and the block tracks packet boundaries by parsing each header as it goes past.

The host can abandon the rest of the current packet. It writes 1 to the skip bit of the control register. The block then spends a fixed number of cycles moving the read pointer to the first byte of the next packet, and the skip bit reads 1 for that whole time. The bit clears itself when the move is complete, and the buffer-empty flag reflects the new position. A skip is accepted only once the header has been consumed and while more than 8 bytes of the packet remain. A request outside that window is dropped and latches a sticky error bit.

The control register also holds enables for two event interrupts, link failure and signal quality error. Each event has a pending bit that the host clears by writing 1.

Stream rules. On the input, a byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the buffer holds DEPTH bytes, and the producer must then hold its byte. On the output, `out_valid` stays high with stable `out_data` until `out_ready` takes the byte. `out_valid` drops without a transfer only while a skip is running.

Top module: `rx_skip_ctl`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x00, STAT (address 1) reads 0x01, `out_valid` and `irq` are 0, and `in_ready` is 1.
- R2: Input bytes are taken on `in_valid && in_ready`, and `in_ready` is 0 while DEPTH bytes are held. A packet is readable only after its byte with `in_last` is taken. Bytes leave in write order on `out_valid && out_ready`, and `out_data` is 0 whenever `out_valid` is 0.
- R3: Writing CTRL with bit 0 = 1, once the 4 header bytes are read and more than 8 packet bytes remain, makes CTRL bit 0 read 1 and holds `out_valid` at 0 for exactly SKIP_CYCLES cycles. The next byte delivered is then the first byte of the following packet, at header start + 4 + length, where the length comes from header byte 2 (low) and byte 3 (high), taken modulo the buffer size.
- R4: Writing CTRL with bit 0 = 0 starts no skip and leaves the read position unchanged.
- R5: STAT bit 0 (empty) is 1 when no committed unread byte remains. Skipping the last stored packet leaves it at 1 once CTRL bit 0 has returned to 0.
- R6: A skip request made before all 4 header bytes of the current packet are read, including when the buffer is empty, is ignored and sets STAT bit 1.
- R7: A skip request made when 8 or fewer bytes of the current packet remain is ignored and sets STAT bit 1.
- R8: STAT bit 1 stays set until a STAT write with bit 1 = 1 clears it. Writing 0 to that bit leaves it set.
- R9: CTRL bit 1 (link-fail interrupt enable) and bit 2 (signal-quality interrupt enable) are read/write and reset to 0. CTRL bits 7:3 and STAT bits 7:4 always read 0.
- R10: A pulse on `link_fail_evt` sets STAT bit 2 and a pulse on `sqe_evt` sets STAT bit 3. `irq` is 1 while any pending bit has its enable set. Writing 1 to a pending bit clears it, and an event arriving in the same cycle as the clear wins.
- R11: A skip request made while a skip is already running is ignored. It neither extends the busy time nor sets an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer byte valid |
| in_ready | output | 1 | Buffer can take a byte |
| in_data | input | 8 | Producer byte |
| in_last | input | 1 | Byte is the final one of its packet |
| out_valid | output | 1 | Host byte available |
| out_ready | input | 1 | Host takes the byte |
| out_data | output | 8 | Host byte, 0 when not valid |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 STAT |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| link_fail_evt | input | 1 | Link-fail event pulse |
| sqe_evt | input | 1 | Signal-quality-error event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions guard the following on every cycle:
- The skip counter never exceeds its bound and steps once per cycle.
- The read pointer stays frozen while a skip runs, and a skip always ends on a packet boundary.
- Early and late skip requests never start a skip, and a request during a skip never restarts it.
- The fill level never exceeds the buffer depth.
- Pending and error bits latch as required.

Only the bench scenarios can show the rest:
- That the landing address is really the next header, which needs the length read in the right byte order.
- The exact busy duration seen from the register.
- The empty flag after skipping the last packet.
- Data order across pointer wrap-around.
- Back-pressure with a completely full buffer.

// File: rtl/rsk_pkg.sv
package rsk_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;

  localparam int CTRL_SKIP_BIT  = 0;
  localparam int CTRL_EN_BASE   = 1;
  localparam int STAT_EMPTY_BIT = 0;
  localparam int STAT_ERR_BIT   = 1;
  localparam int STAT_PEND_BASE = 2;

  localparam int NUM_EVT     = 2;
  localparam int HDR_BYTES   = 4;
  localparam int GUARD_BYTES = 8;
  localparam int OFF_W       = 17;

  typedef enum logic {
    SK_IDLE = 1'b0,
    SK_RUN  = 1'b1
  } skip_state_e;
endpackage

// File: rtl/rsk_buffer.sv
module rsk_buffer #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [PTR_W:0]    rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic              avail
);
  localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W:0]    wr_ptr_q;
  logic [PTR_W:0]    commit_q;
  logic [PTR_W:0]    fill;
  logic              accept;

  assign fill     = wr_ptr_q - rd_ptr;
  assign in_ready = (fill != FULL_LVL);
  assign accept   = in_valid && in_ready;
  assign avail    = (commit_q != rd_ptr);
  assign rd_data  = mem[rd_ptr[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr_q[PTR_W-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      commit_q <= '0;
    end else if (accept) begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (in_last) commit_q <= wr_ptr_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(wr_ptr_q)); // R2
  AST_COMMIT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_q - rd_ptr) <= fill); // R2
endmodule

// File: rtl/rsk_skip_ctrl.sv
module rsk_skip_ctrl
  import rsk_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int SKIP_CYCLES = 20,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           avail,
  input  logic [7:0]     rd_data,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [7:0]     out_data,
  input  logic           skip_req,
  output logic           busy,
  output logic           err_set,
  output logic [PTR_W:0] rd_ptr
);
  localparam int CNT_W = $clog2(SKIP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SKIP_CYCLES - 1);

  skip_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] offset_q;
  logic [7:0]       len_lo_q, len_hi_q;
  logic [PTR_W:0]   start_q;

  logic [15:0]      len_now;
  logic [OFF_W-1:0] total_now, total_q, remain;
  logic [PTR_W:0]   next_start;
  logic             fire, last_byte, hdr_done, near_end, legal, cnt_last;

  assign busy      = (st_q == SK_RUN);
  assign out_valid = avail && !busy;
  assign out_data  = out_valid ? rd_data : 8'h00;
  assign fire      = out_valid && out_ready;

  // the high length byte is still on the data port while offset 3 is read
  assign len_now   = (offset_q == OFF_W'(3)) ? {rd_data, len_lo_q} : {len_hi_q, len_lo_q};
  assign total_now = OFF_W'(HDR_BYTES) + OFF_W'(len_now);
  assign last_byte = (offset_q >= OFF_W'(3)) && (offset_q + 1'b1 == total_now);

  assign total_q    = OFF_W'(HDR_BYTES) + OFF_W'({len_hi_q, len_lo_q});
  assign remain     = total_q - offset_q;
  assign hdr_done   = offset_q >= OFF_W'(HDR_BYTES);
  assign near_end   = remain <= OFF_W'(GUARD_BYTES);
  assign legal      = hdr_done && !near_end;
  assign err_set    = skip_req && !busy && !legal;
  assign next_start = start_q + (PTR_W+1)'(total_q);
  assign cnt_last   = (cnt_q == CNT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SK_IDLE;
      cnt_q    <= '0;
      offset_q <= '0;
      len_lo_q <= '0;
      len_hi_q <= '0;
      start_q  <= '0;
      rd_ptr   <= '0;
    end else begin
      case (st_q)
        SK_IDLE: begin
          if (fire) begin
            rd_ptr <= rd_ptr + 1'b1;
            if (offset_q == OFF_W'(2)) len_lo_q <= rd_data;
            if (offset_q == OFF_W'(3)) len_hi_q <= rd_data;
            if (last_byte) begin
              offset_q <= '0;
              start_q  <= rd_ptr + 1'b1;
            end else begin
              offset_q <= offset_q + 1'b1;
            end
          end
          if (skip_req && legal) begin
            st_q  <= SK_RUN;
            cnt_q <= '0;
          end
        end
        SK_RUN: begin
          if (cnt_last) begin
            st_q     <= SK_IDLE;
            cnt_q    <= '0;
            rd_ptr   <= next_start;
            start_q  <= next_start;
            offset_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SK_IDLE;
      endcase
    end
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q < CNT_W'(SKIP_CYCLES)); // R3
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && rst_n) |-> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_last) |=> $stable(rd_ptr)); // R3
  AST_LAND_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (offset_q == '0 && rd_ptr == start_q)); // R3
  AST_EARLY_SKIP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_req && !busy && offset_q < OFF_W'(HDR_BYTES)) |=> !busy); // R6
  AST_LATE_SKIP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_req && !busy && hdr_done && remain <= OFF_W'(GUARD_BYTES)) |=> !busy); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_last) |=> busy); // R11
endmodule

// File: rtl/rsk_ctrl_regs.sv
module rsk_ctrl_regs
  import rsk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               busy,
  input  logic               empty,
  input  logic               err_set,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               skip_req,
  output logic               irq
);
  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] pend_q;
  logic               err_q;
  logic               wr_ctrl, wr_stat;
  logic               unused_wdata;

  assign wr_ctrl      = reg_we && (reg_addr == ADDR_CTRL);
  assign wr_stat      = reg_we && (reg_addr == ADDR_STAT);
  assign skip_req     = wr_ctrl && reg_wdata[CTRL_SKIP_BIT];
  assign irq          = |(pend_q & en_q);
  assign unused_wdata = ^reg_wdata[7:STAT_PEND_BASE+NUM_EVT];

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[e]   <= 1'b0;
        pend_q[e] <= 1'b0;
      end else begin
        if (wr_ctrl) en_q[e] <= reg_wdata[CTRL_EN_BASE+e];
        if (evt_in[e]) pend_q[e] <= 1'b1;
        else if (wr_stat && reg_wdata[STAT_PEND_BASE+e]) pend_q[e] <= 1'b0;
      end
    end

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_in[e] |=> pend_q[e]); // R10
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (wr_stat && reg_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_SKIP_BIT] = busy;
        reg_rdata[CTRL_EN_BASE +: NUM_EVT] = en_q;
      end
      ADDR_STAT: begin
        reg_rdata[STAT_EMPTY_BIT] = empty;
        reg_rdata[STAT_ERR_BIT]   = err_q;
        reg_rdata[STAT_PEND_BASE +: NUM_EVT] = pend_q;
      end
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend_q)); // R10
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_q); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_stat && reg_wdata[STAT_ERR_BIT])) |=> err_q); // R8
endmodule

// File: rtl/rx_skip_ctl.sv
module rx_skip_ctl
  import rsk_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int SKIP_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       link_fail_evt,
  input  logic       sqe_evt,
  output logic       irq
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W:0]     rd_ptr;
  logic [7:0]         rd_data;
  logic               avail, busy, err_set, skip_req;
  logic [NUM_EVT-1:0] evt_in;

  assign evt_in = {sqe_evt, link_fail_evt};

  rsk_buffer #(.DEPTH(DEPTH), .DATA_W(8)) buf_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .rd_ptr(rd_ptr), .rd_data(rd_data), .avail(avail)
  );

  rsk_skip_ctrl #(.DEPTH(DEPTH), .SKIP_CYCLES(SKIP_CYCLES)) skip_i (
    .clk(clk), .rst_n(rst_n),
    .avail(avail), .rd_data(rd_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .skip_req(skip_req), .busy(busy), .err_set(err_set), .rd_ptr(rd_ptr)
  );

  rsk_ctrl_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .empty(!avail), .err_set(err_set), .evt_in(evt_in),
    .skip_req(skip_req), .irq(irq)
  );
endmodule

// File: tb/rx_skip_ctl_tb.sv
module rx_skip_ctl_tb_top;
  localparam int DEPTH = 512;
  localparam int SC    = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, reg_we = 1'b0;
  logic [7:0] in_data = 8'h00, reg_wdata = 8'h00;
  logic [1:0] reg_addr = 2'd0;
  logic       link_fail_evt = 1'b0, sqe_evt = 1'b0;
  logic       in_ready, out_valid, irq;
  logic [7:0] out_data, reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_skip_ctl #(.DEPTH(DEPTH), .SKIP_CYCLES(SC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_fail_evt(link_fail_evt), .sqe_evt(sqe_evt), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  function automatic logic [7:0] pkt_byte(input logic [7:0] tag, input int len, input int i);
    case (i)
      0: return tag;
      1: return ~tag;
      2: return len[7:0];
      3: return len[15:8];
      default: return tag + 8'(i * 3);
    endcase
  endfunction

  task automatic push(input logic [7:0] d, input logic last);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic push_pkt(input logic [7:0] tag, input int len);
    for (int i = 0; i < len + 4; i++) push(pkt_byte(tag, len, i), i == len + 3);
  endtask

  task automatic pull(input logic [7:0] exp, input string req);
    int w = 0;
    @(negedge clk);
    while (!out_valid && w < 100) begin w++; @(negedge clk); end
    chk(req, "out byte", int'(out_data), int'(exp));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic skip_busy_len(output int n, output int leak);
    logic [7:0] v;
    n = 0; leak = 0;
    rd_reg(2'd0, v);
    while (v[0] && n < 1000) begin
      n++;
      if (out_valid) leak++;
      @(negedge clk);
      rd_reg(2'd0, v);
    end
  endtask

  initial begin
    int n, leak;
    logic [7:0] v;
    logic legal;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and R2 idle output
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "irq", int'(irq), 0);
    rd_reg(2'd0, v); chk("R1", "CTRL", int'(v), 8'h00);
    rd_reg(2'd1, v); chk("R1", "STAT", int'(v), 8'h01);
    chk("R2", "out_data idle", int'(out_data), 0);

    // R9 enables read/write, unused bits zero; R4 bit0=0 starts nothing
    wr_reg(2'd0, 8'hFE);
    rd_reg(2'd0, v); chk("R9", "CTRL readback", int'(v), 8'h06);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v); chk("R9", "CTRL cleared", int'(v), 8'h00);
    wr_reg(2'd1, 8'hF0);
    rd_reg(2'd1, v); chk("R9", "STAT unused", int'(v), 8'h01);

    // R10 events and interrupt
    @(negedge clk); link_fail_evt = 1'b1; @(negedge clk); link_fail_evt = 1'b0;
    rd_reg(2'd1, v); chk("R10", "link pend", int'(v[2]), 1);
    chk("R10", "irq masked", int'(irq), 0);
    wr_reg(2'd0, 8'h02); chk("R10", "irq link en", int'(irq), 1);
    wr_reg(2'd1, 8'h04);
    rd_reg(2'd1, v); chk("R10", "link pend clr", int'(v[2]), 0);
    chk("R10", "irq after clr", int'(irq), 0);
    @(negedge clk); sqe_evt = 1'b1; @(negedge clk); sqe_evt = 1'b0;
    chk("R10", "irq sqe not en", int'(irq), 0);
    wr_reg(2'd0, 8'h04); chk("R10", "irq sqe en", int'(irq), 1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h08; sqe_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00; sqe_evt = 1'b0;
    rd_reg(2'd1, v); chk("R10", "set wins clear", int'(v[3]), 1);
    wr_reg(2'd1, 8'h08);
    chk("R10", "irq sqe clr", int'(irq), 0);
    wr_reg(2'd0, 8'h00);

    // R6 skip with empty buffer
    wr_reg(2'd0, 8'h01);
    rd_reg(2'd0, v); chk("R6", "no busy on empty", int'(v[0]), 0);
    rd_reg(2'd1, v); chk("R6", "err on empty", int'(v[1]), 1);
    wr_reg(2'd1, 8'h02);

    // Sweep: every packet length 0..20, skip after every read count
    for (int len = 0; len <= 20; len++) begin
      for (int k = 0; k < len + 4; k++) begin
        logic [7:0] ta, tb;
        ta = 8'(len * 16 + k + 1);
        tb = ta ^ 8'h5C;
        push_pkt(ta, len);
        push_pkt(tb, 2);
        for (int i = 0; i < k; i++) pull(pkt_byte(ta, len, i), "R2");
        legal = (k >= 4) && ((len + 4 - k) > 8);
        wr_reg(2'd0, 8'h01);
        if (legal) begin
          skip_busy_len(n, leak);
          chk("R3", "busy cycles", n, SC);
          chk("R3", "no output while busy", leak, 0);
          rd_reg(2'd1, v); chk("R3", "no err on legal", int'(v[1]), 0);
          pull(tb, "R3");
        end else begin
          rd_reg(2'd0, v); chk(k < 4 ? "R6" : "R7", "busy on bad skip", int'(v[0]), 0);
          rd_reg(2'd1, v); chk(k < 4 ? "R6" : "R7", "err on bad skip", int'(v[1]), 1);
          wr_reg(2'd1, 8'h00);
          rd_reg(2'd1, v); chk("R8", "err kept on 0", int'(v[1]), 1);
          wr_reg(2'd1, 8'h02);
          rd_reg(2'd1, v); chk("R8", "err cleared", int'(v[1]), 0);
          for (int i = k; i < len + 4; i++) pull(pkt_byte(ta, len, i), k < 4 ? "R6" : "R7");
          pull(tb, "R2");
        end
        for (int i = 1; i < 6; i++) pull(pkt_byte(tb, 2, i), "R2");
        rd_reg(2'd1, v); chk("R5", "empty after drain", int'(v[0]), 1);
      end
    end

    // R4 writing 0 to skip bit mid-packet
    push_pkt(8'h31, 10);
    for (int i = 0; i < 5; i++) pull(pkt_byte(8'h31, 10, i), "R4");
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v); chk("R4", "no busy", int'(v[0]), 0);
    for (int i = 5; i < 14; i++) pull(pkt_byte(8'h31, 10, i), "R4");

    // R11 second request during busy
    push_pkt(8'h44, 20);
    push_pkt(8'h55, 2);
    for (int i = 0; i < 4; i++) pull(pkt_byte(8'h44, 20, i), "R11");
    wr_reg(2'd0, 8'h01);
    repeat (4) @(negedge clk);
    wr_reg(2'd0, 8'h01);
    skip_busy_len(n, leak);
    chk("R11", "busy not extended", n + 6, SC);
    rd_reg(2'd1, v); chk("R11", "no err while busy", int'(v[1]), 0);
    for (int i = 0; i < 6; i++) pull(pkt_byte(8'h55, 2, i), "R11");

    // R5 skip the last stored packet
    push_pkt(8'h66, 16);
    for (int i = 0; i < 4; i++) pull(pkt_byte(8'h66, 16, i), "R5");
    rd_reg(2'd1, v); chk("R5", "not empty mid packet", int'(v[0]), 0);
    wr_reg(2'd0, 8'h01);
    skip_busy_len(n, leak);
    rd_reg(2'd1, v); chk("R5", "empty after skip", int'(v[0]), 1);
    chk("R5", "out_valid after skip", int'(out_valid), 0);

    // R3 length with high byte set (260 = 0x0104)
    push_pkt(8'h77, 260);
    push_pkt(8'h88, 2);
    for (int i = 0; i < 4; i++) pull(pkt_byte(8'h77, 260, i), "R3");
    wr_reg(2'd0, 8'h01);
    skip_busy_len(n, leak);
    chk("R3", "busy cycles long pkt", n, SC);
    for (int i = 0; i < 6; i++) pull(pkt_byte(8'h88, 2, i), "R3");

    // R2 full buffer back-pressure
    for (int i = 0; i < DEPTH - 1; i++) push(pkt_byte(8'h99, DEPTH - 4, i), 1'b0);
    @(negedge clk);
    chk("R2", "uncommitted not visible", int'(out_valid), 0);
    push(pkt_byte(8'h99, DEPTH - 4, DEPTH - 1), 1'b1);
    chk("R2", "in_ready full", int'(in_ready), 0);
    chk("R2", "visible after last", int'(out_valid), 1);
    for (int i = 0; i < DEPTH; i++) pull(pkt_byte(8'h99, DEPTH - 4, i), "R2");
    chk("R2", "in_ready after drain", int'(in_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule